// File: doc/BRIEF.md
# Four-Slot Issue Arbiter with Register Scoreboard

This block chooses, in every cycle, which decoded instructions leave two in-order dual-entry queues and which of four issue slots each one takes. The memory-side queue feeds slots 0 and 1. The execute-side queue feeds slots 2 and 3. Each queue entry carries a 5-bit class code, a destination register and two source registers. The block grants each issuing entry a slot that its class allows, and it returns dequeue strobes to both queues.

A countdown scoreboard holds one counter per architectural register. The counter is armed when a producer issues, and it holds back any consumer until the producer's class latency has elapsed. Two producer/consumer pairings are given a shorter latency. One class is single-issue: it takes every slot and nothing issues beside it. Long latencies delay only dependent instructions. A slot is free again in the cycle after an issue.

Top module: `issue_arbiter`

## Requirements
- R1: After reset every register counts as ready. When no entry is valid, no slot is granted and no dequeue strobe is raised. An independent valid entry issues in the cycle it is presented.
- R2: Class codes: 4 load and 5 prefetch may use only slot 0. Codes 6 store and 7 control transfer may use only slot 1. An entry is never granted if its class has no permitted slot on its own queue; this covers codes 17 to 31.
- R3: Codes 0 integer ALU, 1 multiply, 2 divide and 3 instruction flush may use slot 2 or slot 3. Codes 8 float, 9 float divide single, 10 float divide double, 11 square root single, 12 square root double, 13 SIMD, 14 fast SIMD and 15 special register may use only slot 3.
- R4: Code 16 is single-issue. When it issues, all four slot grants rise, every slot_src shows its entry, and no other entry is dequeued. While such an entry sits at either queue head, nothing else issues. If both heads are single-issue, the memory-side head goes first. A single-issue entry in the younger position waits.
- R5: Entry 0 of each queue is the older one. Entry 1 may dequeue only in a cycle in which entry 0 also dequeues.
- R6: slot_src of a slot encodes the granted entry: 0 and 1 are memory-side entries 0 and 1, and 2 and 3 are execute-side entries 0 and 1. The value is 0 when the slot is idle. When both entries of a queue issue, entry 0 takes the lower slot of the pair if entry 1 can use the upper slot. Otherwise entry 0 takes the upper slot. A lone entry takes the lower slot when it may.
- R7: A consumer of a register written by class latency L issues no earlier than L cycles after its producer, and exactly L cycles after it when nothing else blocks it. The latencies are: ALU 1, multiply 10, divide 30, flush 27, load 3, prefetch 1, store 1, control transfer 1, float 9, divide single 26, divide double 30, square root single 33, square root double 41, SIMD 5, fast SIMD 1, special register 70, single-issue 1.
- R8: A multiply feeding a multiply takes 9 cycles. A SIMD (code 13) result feeding another code 13 takes 3 cycles. No other pairing is shortened.
- R9: Register 0 is always ready as a source, and a write to it arms nothing.
- R10: An entry cannot issue in the same cycle as an older same-queue entry that writes one of its sources. An execute-side entry cannot issue beside a memory-side entry that writes one of its sources.
- R11: A long-latency issue does not reserve its slot. The same slot can be granted again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ls_valid | input | 2 | Memory-side entry valid, bit 0 older |
| ls_class | input | 2x5 | Memory-side class codes |
| ls_dst | input | 2x5 | Memory-side destination registers |
| ls_src_a | input | 2x5 | Memory-side first source registers |
| ls_src_b | input | 2x5 | Memory-side second source registers |
| ex_valid | input | 2 | Execute-side entry valid, bit 0 older |
| ex_class | input | 2x5 | Execute-side class codes |
| ex_dst | input | 2x5 | Execute-side destination registers |
| ex_src_a | input | 2x5 | Execute-side first source registers |
| ex_src_b | input | 2x5 | Execute-side second source registers |
| slot_grant | output | 4 | Per-slot issue grant |
| slot_src | output | 4x2 | Entry bound to each slot |
| ls_deq | output | 2 | Memory-side dequeue strobes |
| ex_deq | output | 2 | Execute-side dequeue strobes |

## Verification
The bench measures the issue distance for every class. An off-by-one in the counter load shows up as every dependent arriving one cycle late or early. It pairs multiply with multiply and SIMD with SIMD, so a missing or over-broad shortening changes the measured distance. It offers slot-3-only entries in the older and in the younger position, which catches a binder that puts both on one slot or leaves a flexible entry stranded. It places single-issue entries at each head, in the younger position and at both heads at once. It also places same-cycle producers in front of their consumers. A design that ignores these cases issues past a hazard or lets a companion slip alongside a serializing instruction.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int CLS_W = 5;
  localparam int CNT_W = 7;

  typedef enum logic [CLS_W-1:0] {
    C_IALU = 5'd0, C_IMUL = 5'd1, C_IDIV = 5'd2, C_IFLUSH = 5'd3,
    C_LOAD = 5'd4, C_PREF = 5'd5, C_STORE = 5'd6, C_CTI = 5'd7,
    C_FP = 5'd8, C_FDIVS = 5'd9, C_FDIVD = 5'd10, C_FSQRTS = 5'd11,
    C_FSQRTD = 5'd12, C_SIMD = 5'd13, C_SIMD1 = 5'd14, C_SREG = 5'd15,
    C_SINGLE = 5'd16
  } iclass_e;

  // Cycles from issue until a dependent may issue.
  function automatic logic [CNT_W-1:0] cls_latency(input logic [CLS_W-1:0] c);
    case (c)
      C_IMUL:   return CNT_W'(10);
      C_IDIV:   return CNT_W'(30);
      C_IFLUSH: return CNT_W'(27);
      C_LOAD:   return CNT_W'(3);
      C_FP:     return CNT_W'(9);
      C_FDIVS:  return CNT_W'(26);
      C_FDIVD:  return CNT_W'(30);
      C_FSQRTS: return CNT_W'(33);
      C_FSQRTD: return CNT_W'(41);
      C_SIMD:   return CNT_W'(5);
      C_SREG:   return CNT_W'(70);
      default:  return CNT_W'(1);
    endcase
  endfunction

  // Bit n set: slot n allowed.
  function automatic logic [3:0] cls_slots(input logic [CLS_W-1:0] c);
    case (c)
      C_IALU, C_IMUL, C_IDIV, C_IFLUSH: return 4'b1100;
      C_LOAD, C_PREF:                   return 4'b0001;
      C_STORE, C_CTI:                   return 4'b0010;
      C_FP, C_FDIVS, C_FDIVD, C_FSQRTS,
      C_FSQRTD, C_SIMD, C_SIMD1, C_SREG: return 4'b1000;
      C_SINGLE:                         return 4'b1111;
      default:                          return 4'b0000;
    endcase
  endfunction

  // Slot pair local to one queue: bit 0 lower slot, bit 1 upper slot.
  function automatic logic [1:0] half_mask(input logic [CLS_W-1:0] c, input logic upper);
    logic [3:0] m;
    m = cls_slots(c);
    return upper ? m[3:2] : m[1:0];
  endfunction

  function automatic logic is_single(input logic [CLS_W-1:0] c);
    return c == C_SINGLE;
  endfunction

  // Cycles of remaining count a consumer may tolerate from this producer.
  function automatic logic [CNT_W-1:0] bypass_slack(input logic [CLS_W-1:0] prod,
                                                    input logic [CLS_W-1:0] cons);
    if (prod == C_IMUL && cons == C_IMUL) return CNT_W'(1);
    if (prod == C_SIMD && cons == C_SIMD) return CNT_W'(2);
    return '0;
  endfunction
endpackage

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import issue_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int NPORT = 4,
  localparam int RW   = $clog2(NREG)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NPORT-1:0]                 wr_en,
  input  logic [NPORT-1:0][RW-1:0]         wr_dst,
  input  logic [NPORT-1:0][CLS_W-1:0]      wr_cls,
  input  logic [NPORT-1:0][CLS_W-1:0]      rd_cls,
  input  logic [NPORT-1:0][1:0][RW-1:0]    rd_src,
  output logic [NPORT-1:0]                 rd_ok
);
  logic [CNT_W-1:0] cnt_all [NREG];
  logic [CLS_W-1:0] cls_all [NREG];

  assign cnt_all[0] = '0;
  assign cls_all[0] = '0;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    logic             hit;
    logic             en;
    logic [CNT_W-1:0] nxt_cnt, cnt_q;
    logic [CLS_W-1:0] nxt_cls, cls_q;

    always_comb begin
      hit     = 1'b0;
      nxt_cnt = cnt_q;
      nxt_cls = cls_q;
      for (int p = 0; p < NPORT; p++) begin
        if (wr_en[p] && wr_dst[p] == RW'(r)) begin
          hit     = 1'b1;
          nxt_cnt = cls_latency(wr_cls[p]) - CNT_W'(1);
          nxt_cls = wr_cls[p];
        end
      end
      if (!hit && cnt_q != '0) nxt_cnt = cnt_q - CNT_W'(1);
      en = hit || (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        cls_q <= '0;
      end else if (en) begin
        cnt_q <= nxt_cnt;
        cls_q <= nxt_cls;
      end
    end

    assign cnt_all[r] = cnt_q;
    assign cls_all[r] = cls_q;

    // R7: an unwritten busy counter drops by exactly one per cycle
    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !hit) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rd_ok[p] = 1'b1;
      for (int s = 0; s < 2; s++) begin
        if (cnt_all[rd_src[p][s]] > bypass_slack(cls_all[rd_src[p][s]], rd_cls[p]))
          rd_ok[p] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/issue_pair_pick.sv
module issue_pair_pick (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] vld,
  input  logic [1:0] rdy,
  input  logic [1:0] mask0,
  input  logic [1:0] mask1,
  output logic [1:0] deq,
  output logic [1:0] grant,
  output logic [1:0] sel
);
  logic iss0, iss1, opt_a, opt_b;

  always_comb begin
    iss0  = vld[0] && rdy[0] && (mask0 != 2'b00);
    opt_a = mask0[0] && mask1[1];
    opt_b = mask0[1] && mask1[0];
    iss1  = iss0 && vld[1] && rdy[1] && (opt_a || opt_b);
    deq   = {iss1, iss0};
    grant = 2'b00;
    sel   = 2'b00;
    if (iss1) begin
      grant = 2'b11;
      sel   = opt_a ? 2'b10 : 2'b01;
    end else if (iss0) begin
      grant = mask0[0] ? 2'b01 : 2'b10;
    end
  end

  // R5: younger never leaves without the older one
  a_r5_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    deq[1] |-> deq[0]);
  // R6: each issuing entry sits on a slot its class permits
  a_r6_legal_bind: assert property (@(posedge clk) disable iff (!rst_n)
    (deq == 2'b11) |-> (sel[0] ? (mask1[0] && mask0[1]) : (mask0[0] && mask1[1])));
endmodule

// File: rtl/issue_arbiter.sv
module issue_arbiter
  import issue_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 ls_valid,
  input  logic [1:0][CLS_W-1:0]      ls_class,
  input  logic [1:0][RW-1:0]         ls_dst,
  input  logic [1:0][RW-1:0]         ls_src_a,
  input  logic [1:0][RW-1:0]         ls_src_b,
  input  logic [1:0]                 ex_valid,
  input  logic [1:0][CLS_W-1:0]      ex_class,
  input  logic [1:0][RW-1:0]         ex_dst,
  input  logic [1:0][RW-1:0]         ex_src_a,
  input  logic [1:0][RW-1:0]         ex_src_b,
  output logic [3:0]                 slot_grant,
  output logic [3:0][1:0]            slot_src,
  output logic [1:0]                 ls_deq,
  output logic [1:0]                 ex_deq
);
  function automatic logic reads_reg(input logic [RW-1:0] a, input logic [RW-1:0] b,
                                     input logic [RW-1:0] d);
    return (d != '0) && (a == d || b == d);
  endfunction

  logic [3:0]              sb_ok;
  logic [3:0][1:0][RW-1:0] rd_src;
  logic [1:0]              ls_rdy, ex_rdy;
  logic [1:0]              lsp_deq, lsp_grant, lsp_sel;
  logic [1:0]              exp_deq, exp_grant, exp_sel;
  logic                    ls_head_single, ex_head_single;

  always_comb begin
    for (int e = 0; e < 2; e++) begin
      rd_src[e]     = {ls_src_b[e], ls_src_a[e]};
      rd_src[e + 2] = {ex_src_b[e], ex_src_a[e]};
    end
  end

  issue_scoreboard #(.NREG(NREG), .NPORT(4)) u_sb (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  ({ex_deq, ls_deq}),
    .wr_dst ({ex_dst, ls_dst}),
    .wr_cls ({ex_class, ls_class}),
    .rd_cls ({ex_class, ls_class}),
    .rd_src (rd_src),
    .rd_ok  (sb_ok)
  );

  // Memory side is resolved first; execute side sees its same-cycle writes.
  always_comb begin
    ls_rdy[0] = sb_ok[0];
    ls_rdy[1] = sb_ok[1] && !is_single(ls_class[1])
             && !reads_reg(ls_src_a[1], ls_src_b[1], ls_dst[0]);
    for (int e = 0; e < 2; e++) begin
      ex_rdy[e] = sb_ok[e + 2]
               && !(lsp_deq[0] && reads_reg(ex_src_a[e], ex_src_b[e], ls_dst[0]))
               && !(lsp_deq[1] && reads_reg(ex_src_a[e], ex_src_b[e], ls_dst[1]));
    end
    ex_rdy[1] = ex_rdy[1] && !is_single(ex_class[1])
             && !reads_reg(ex_src_a[1], ex_src_b[1], ex_dst[0]);
  end

  issue_pair_pick u_ls_pick (
    .clk (clk), .rst_n (rst_n), .vld (ls_valid), .rdy (ls_rdy),
    .mask0 (half_mask(ls_class[0], 1'b0)), .mask1 (half_mask(ls_class[1], 1'b0)),
    .deq (lsp_deq), .grant (lsp_grant), .sel (lsp_sel)
  );

  issue_pair_pick u_ex_pick (
    .clk (clk), .rst_n (rst_n), .vld (ex_valid), .rdy (ex_rdy),
    .mask0 (half_mask(ex_class[0], 1'b1)), .mask1 (half_mask(ex_class[1], 1'b1)),
    .deq (exp_deq), .grant (exp_grant), .sel (exp_sel)
  );

  assign ls_head_single = ls_valid[0] && is_single(ls_class[0]);
  assign ex_head_single = ex_valid[0] && is_single(ex_class[0]);

  always_comb begin
    slot_grant = '0;
    slot_src   = '0;
    ls_deq     = '0;
    ex_deq     = '0;
    if (ls_head_single) begin
      if (sb_ok[0]) begin
        slot_grant = 4'hF;
        ls_deq     = 2'b01;
      end
    end else if (ex_head_single) begin
      if (sb_ok[2]) begin
        slot_grant = 4'hF;
        slot_src   = {4{2'd2}};
        ex_deq     = 2'b01;
      end
    end else begin
      slot_grant  = {exp_grant, lsp_grant};
      slot_src[0] = {1'b0, lsp_sel[0]};
      slot_src[1] = {1'b0, lsp_sel[1]};
      slot_src[2] = {exp_grant[0], exp_sel[0]};
      slot_src[3] = {exp_grant[1], exp_sel[1]};
      ls_deq      = lsp_deq;
      ex_deq      = exp_deq;
    end
  end

  logic [CLS_W-1:0] s0_cls, s3_cls;
  assign s0_cls = slot_src[0][0] ? ls_class[1] : ls_class[0];
  assign s3_cls = slot_src[3][0] ? ex_class[1] : ex_class[0];

  // R4: a serializing grant dequeues exactly one entry
  a_r4_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_grant == 4'hF && slot_src[0] == slot_src[3]) |-> ($countones({ex_deq, ls_deq}) == 1));
  // R2: slot 0 carries only load or prefetch outside serialization
  a_r2_slot0_class: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_grant[0] && !slot_src[0][1] && !is_single(s0_cls)) |->
      (s0_cls == C_LOAD || s0_cls == C_PREF));
  // R3: execute-side entry on slot 3 has a class allowed there
  a_r3_slot3_class: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_grant[3] && slot_src[3][1] && !is_single(s3_cls)) |->
      ((cls_slots(s3_cls) & 4'b1000) != 4'b0000));
endmodule

// File: tb/issue_arbiter_tb.sv
module issue_arbiter_tb;
  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      ls_valid, ex_valid;
  logic [1:0][4:0] ls_class, ls_dst, ls_src_a, ls_src_b;
  logic [1:0][4:0] ex_class, ex_dst, ex_src_a, ex_src_b;
  logic [3:0]      slot_grant;
  logic [3:0][1:0] slot_src;
  logic [1:0]      ls_deq, ex_deq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  issue_arbiter u_dut (
    .clk, .rst_n, .ls_valid, .ls_class, .ls_dst, .ls_src_a, .ls_src_b,
    .ex_valid, .ex_class, .ex_dst, .ex_src_a, .ex_src_b,
    .slot_grant, .slot_src, .ls_deq, .ex_deq
  );

  typedef struct packed {
    logic [1:0] lv; logic [4:0] lc0; logic [4:0] lc1;
    logic [1:0] xv; logic [4:0] xc0; logic [4:0] xc1;
    logic [3:0] g;  logic [7:0] s;   logic [1:0] ld; logic [1:0] xd;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'b11, 5'd4,  5'd6,  2'b11, 5'd0,  5'd8,  4'hF, 8'b11_10_01_00, 2'b11, 2'b11}, // R2 R3 R6
    '{2'b11, 5'd6,  5'd4,  2'b11, 5'd8,  5'd0,  4'hF, 8'b10_11_00_01, 2'b11, 2'b11}, // R6 swapped
    '{2'b11, 5'd4,  5'd5,  2'b11, 5'd8,  5'd13, 4'b1001, 8'b10_00_00_00, 2'b01, 2'b01}, // R2 R3 conflicts
    '{2'b01, 5'd7,  5'd0,  2'b11, 5'd0,  5'd1,  4'b1110, 8'b11_10_00_00, 2'b01, 2'b11}, // R2 R3
    '{2'b00, 5'd0,  5'd0,  2'b01, 5'd0,  5'd0,  4'b0100, 8'b00_10_00_00, 2'b00, 2'b01}, // R6 lone
    '{2'b11, 5'd16, 5'd4,  2'b01, 5'd0,  5'd0,  4'hF, 8'b00_00_00_00, 2'b01, 2'b00}, // R4 mem head
    '{2'b01, 5'd4,  5'd0,  2'b11, 5'd16, 5'd0,  4'hF, 8'b10_10_10_10, 2'b00, 2'b01}, // R4 exe head
    '{2'b11, 5'd4,  5'd16, 2'b00, 5'd0,  5'd0,  4'b0001, 8'b00_00_00_00, 2'b01, 2'b00}, // R4 younger
    '{2'b01, 5'd0,  5'd0,  2'b00, 5'd0,  5'd0,  4'b0000, 8'b00_00_00_00, 2'b00, 2'b00}, // R2 wrong queue
    '{2'b10, 5'd4,  5'd4,  2'b00, 5'd0,  5'd0,  4'b0000, 8'b00_00_00_00, 2'b00, 2'b00}, // R5 only younger
    '{2'b00, 5'd0,  5'd0,  2'b11, 5'd13, 5'd0,  4'b1100, 8'b10_11_00_00, 2'b00, 2'b11}, // R6 slot3-only older
    '{2'b01, 5'd16, 5'd0,  2'b01, 5'd16, 5'd0,  4'hF, 8'b00_00_00_00, 2'b01, 2'b00}  // R4 both heads
  };

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    ls_valid = '0; ls_class = '0; ls_dst = '0; ls_src_a = '0; ls_src_b = '0;
    ex_valid = '0; ex_class = '0; ex_dst = '0; ex_src_a = '0; ex_src_b = '0;
  endtask

  function automatic int exp_lat(input int c);
    case (c)
      1: return 10;  2: return 30;  3: return 27;  4: return 3;
      8: return 9;   9: return 26;  10: return 30; 11: return 33;
      12: return 41; 13: return 5;  15: return 70;
      default: return 1;
    endcase
  endfunction

  // Producer in cycle t writing rg; consumer offered from t+1 reading rg.
  task automatic meas(input int pc, input int cc, input logic [4:0] rg, input bit use_b,
                      input int exp, input string tag);
    int n;
    bit on_mem;
    on_mem = (pc >= 4 && pc <= 7) || pc == 16;
    @(negedge clk); clr();
    if (on_mem) begin
      ls_valid = 2'b01; ls_class[0] = 5'(pc); ls_dst[0] = rg;
    end else begin
      ex_valid = 2'b01; ex_class[0] = 5'(pc); ex_dst[0] = rg;
    end
    #1;
    chk(on_mem ? ls_deq[0] : ex_deq[0], tag, "producer issue", 32'(pc), 1);
    @(negedge clk); clr();
    ex_valid = 2'b01; ex_class[0] = 5'(cc);
    if (use_b) ex_src_b[0] = rg; else ex_src_a[0] = rg;
    #1;
    n = 1;
    while (!ex_deq[0] && n < 200) begin
      @(negedge clk); #1; n++;
    end
    chk(n == exp, tag, $sformatf("issue distance prod %0d cons %0d", pc, cc), 32'(n), 32'(exp));
    @(negedge clk); clr();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    clr();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle in reset
    chk(slot_grant == 0 && ls_deq == 0 && ex_deq == 0, "R1", "idle grants",
        {slot_grant, ls_deq, ex_deq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ex_valid = 2'b01; ex_src_a[0] = 5'd5; ex_src_b[0] = 5'd7;
    #1;
    chk(ex_deq == 2'b01 && slot_grant == 4'b0100, "R1", "ready after reset",
        {slot_grant, ex_deq}, {4'b0100, 2'b01});
    @(negedge clk); clr();

    // Table of dependency-free patterns
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); clr();
      ls_valid = VEC[i].lv; ls_class[0] = VEC[i].lc0; ls_class[1] = VEC[i].lc1;
      ex_valid = VEC[i].xv; ex_class[0] = VEC[i].xc0; ex_class[1] = VEC[i].xc1;
      #1;
      chk(slot_grant == VEC[i].g && slot_src == VEC[i].s && ls_deq == VEC[i].ld
          && ex_deq == VEC[i].xd, "R2/R3/R4/R5/R6", $sformatf("vector %0d", i),
          {slot_grant, slot_src, ls_deq, ex_deq},
          {VEC[i].g, VEC[i].s, VEC[i].ld, VEC[i].xd});
    end
    @(negedge clk); clr();

    // R7: every class latency
    for (int c = 0; c < 17; c++) meas(c, 0, 5'd5, c[0], exp_lat(c), "R7");

    // R8: shortened pairings and their non-matching partners
    meas(1, 1, 5'd6, 1'b0, 9, "R8");
    meas(1, 2, 5'd6, 1'b1, 10, "R8");
    meas(13, 13, 5'd8, 1'b0, 3, "R8");
    meas(13, 8, 5'd8, 1'b1, 5, "R8");

    // R9: register 0 never waits
    meas(2, 0, 5'd0, 1'b0, 1, "R9");

    // R10: same-queue hazard
    @(negedge clk); clr();
    ex_valid = 2'b11; ex_dst[0] = 5'd7; ex_src_a[1] = 5'd7;
    #1;
    chk(ex_deq == 2'b01, "R10", "younger reads older dst", 32'(ex_deq), 1);
    @(negedge clk); clr();
    ex_valid = 2'b01; ex_src_a[0] = 5'd7;
    #1;
    chk(ex_deq == 2'b01, "R10", "dependent next cycle", 32'(ex_deq), 1);
    // R10: cross-queue hazard
    @(negedge clk); clr();
    ls_valid = 2'b01; ls_class[0] = 5'd4; ls_dst[0] = 5'd9;
    ex_valid = 2'b01; ex_src_b[0] = 5'd9;
    #1;
    chk(ls_deq == 2'b01 && ex_deq == 2'b00, "R10", "exe reads mem dst",
        {ls_deq, ex_deq}, {2'b01, 2'b00});
    @(negedge clk); clr();
    repeat (4) @(negedge clk);

    // R11: slot free right after a long-latency issue
    ex_valid = 2'b01; ex_class[0] = 5'd10;
    #1;
    chk(slot_grant == 4'b1000, "R11", "long op slot3", 32'(slot_grant), 32'h8);
    @(negedge clk); clr();
    ex_valid = 2'b01; ex_class[0] = 5'd8;
    #1;
    chk(slot_grant == 4'b1000 && ex_deq == 2'b01, "R11", "slot3 reused",
        {slot_grant, ex_deq}, {4'b1000, 2'b01});
    @(negedge clk); clr();

    report();
    $finish;
  end
endmodule